// File: doc/BRIEF.md
# Fixed-Point Leaky Integrate-and-Fire Neuron

This block models one leaky integrate-and-fire neuron in signed fixed-point arithmetic. On every clock cycle it takes one forward-Euler step of the membrane voltage. The step is `v + dt * (I - (v - v_rest)) / tau_m`, where `I` is a signed input current held on a port. The register width and the number of fraction bits are parameters. The same source therefore builds as Q8.8 (the default), Q4.12 or Q16.16. The time step, time constant, resting voltage, firing threshold and post-spike voltage are raw encoded parameters in that format.

The firing decision is made on the freshly computed voltage, not on the stored one. A crossing is therefore reported on the same clock edge that would have stored it. On that edge the stored voltage is replaced by the post-spike value. Every intermediate result clamps at the format's extremes. Elaboration stops with an error when the time step or the time constant encodes to zero, or when the time constant cannot be represented.

Top module: `lif_neuron`

## Requirements
- R1: While `rst_n` is low, `v_out` equals the resting voltage and `spike_out` is 0. Asserting `rst_n` takes effect without waiting for a clock edge.
- R2: On each rising edge with `rst_n` high, the next voltage is formed in four steps. First d = v − v_rest, then g = I − d. Next p = (dt·g) computed at double width and arithmetic-shifted right by the fraction count. Finally v + p/tau.
- R3: The division by tau sign-extends p to double width and shifts it left by the fraction count. It then divides by the sign-extended tau and rounds toward zero. For example, in Q16.16 with tau = 10.0, an input of 3.0 gives a first step of raw 19660.
- R4: When the newly computed voltage is strictly greater than the threshold, the same rising edge sets `spike_out` to 1 and loads `v_out` with the post-spike voltage.
- R5: When the newly computed voltage is not above the threshold, that edge sets `spike_out` to 0 and loads `v_out` with the computed voltage. `spike_out` is therefore a one-cycle pulse unless the next step crosses again.
- R6: Each difference, sum, product and quotient saturates to the most positive (2^(W−1)−1) or most negative (−2^(W−1)) raw value instead of wrapping.
- R7: With zero input current, a resting voltage of 0 and a positive threshold, the neuron never fires.
- R8: In Q8.8 with dt = 1.0, tau = 10.0, threshold 1.0 and a constant input of raw 12800 (50.0), the neuron fires on each of the first 200 cycles after reset.
- R9: The same design works as Q4.12 (16 bits, 12 fraction bits) and as Q16.16 (32 bits, 16 fraction bits), following R2 to R6 in each format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one Euler step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_cur | input | WIDTH | Signed input current, raw fixed-point |
| spike_out | output | 1 | High for the cycle after a step that crossed threshold |
| v_out | output | WIDTH | Signed stored membrane voltage, raw fixed-point |

## Verification
Reset is asynchronous, so its effect on both outputs is due at once and is checked before any clock edge follows. Each Euler step is due on the first rising edge after its input current is applied. The bench changes inputs and samples outputs on falling edges. Each sample therefore sees exactly one new step, which it compares against a behavioural integer model advanced once per cycle. Spike and voltage share one edge (R4). A crossing must appear in the very sample whose model step crossed, and any one-cycle lag shows up as a mismatch.

// File: rtl/lif_pkg.sv
package lif_pkg;

  // Selects what the voltage register loads on a step.
  typedef enum logic {
    UPD_INTEGRATE = 1'b0,
    UPD_FIRE      = 1'b1
  } upd_e;

endpackage

// File: rtl/lif_qsat.sv
// Clamp a double-width signed value into the W-bit signed range.
module lif_qsat #(
  parameter int W = 16
) (
  input  logic signed [2*W-1:0] wide_i,
  output logic signed [W-1:0]   narrow_o
);
  localparam int DW = 2 * W;
  localparam logic signed [DW-1:0] HI_W = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [DW-1:0] LO_W = {{(W+1){1'b1}}, {(W-1){1'b0}}};

  always_comb begin
    if (wide_i > HI_W)      narrow_o = HI_W[W-1:0];
    else if (wide_i < LO_W) narrow_o = LO_W[W-1:0];
    else                    narrow_o = wide_i[W-1:0];
  end
endmodule

// File: rtl/lif_qaddsub.sv
// Saturating add or subtract of two W-bit signed values.
module lif_qaddsub #(
  parameter int W   = 16,
  parameter bit SUB = 1'b0
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] y_o
);
  localparam int DW = 2 * W;
  logic signed [DW-1:0] a_w, b_w, r_w;

  assign a_w = {{W{a_i[W-1]}}, a_i};
  assign b_w = {{W{b_i[W-1]}}, b_i};

  generate
    if (SUB) begin : g_sub
      assign r_w = a_w - b_w;
    end else begin : g_add
      assign r_w = a_w + b_w;
    end
  endgenerate

  lif_qsat #(.W(W)) u_sat (.wide_i(r_w), .narrow_o(y_o));
endmodule

// File: rtl/lif_qmul.sv
// Q-format multiply: double-width product, shift down by F, saturate.
module lif_qmul #(
  parameter int W = 16,
  parameter int F = 8
) (
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] y_o
);
  localparam int DW = 2 * W;
  logic signed [DW-1:0] a_w, b_w, prod_w, scaled_w;

  assign a_w      = {{W{a_i[W-1]}}, a_i};
  assign b_w      = {{W{b_i[W-1]}}, b_i};
  assign prod_w   = a_w * b_w;
  assign scaled_w = prod_w >>> F;

  lif_qsat #(.W(W)) u_sat (.wide_i(scaled_w), .narrow_o(y_o));
endmodule

// File: rtl/lif_qdiv.sv
// Q-format divide by a constant: numerator widened and shifted up by F
// before the divide so the quotient keeps its fraction bits.
module lif_qdiv #(
  parameter int W   = 16,
  parameter int F   = 8,
  parameter int DEN = 2560
) (
  input  logic signed [W-1:0] num_i,
  output logic signed [W-1:0] quo_o
);
  localparam int DW = 2 * W;
  localparam logic signed [DW-1:0] DEN_W = DW'(DEN);

  logic signed [DW-1:0] num_w, num_up, quo_w;

  assign num_w  = {{W{num_i[W-1]}}, num_i};
  assign num_up = num_w <<< F;
  assign quo_w  = num_up / DEN_W;

  lif_qsat #(.W(W)) u_sat (.wide_i(quo_w), .narrow_o(quo_o));
endmodule

// File: rtl/lif_update.sv
// Combinational forward-Euler step of the membrane voltage.
module lif_update #(
  parameter int W         = 16,
  parameter int F         = 8,
  parameter int DT_RAW    = 256,
  parameter int TAU_RAW   = 2560,
  parameter int VREST_RAW = 0
) (
  input  logic signed [W-1:0] v_i,
  input  logic signed [W-1:0] cur_i,
  output logic signed [W-1:0] prod_o,
  output logic signed [W-1:0] quot_o,
  output logic signed [W-1:0] v_next_o
);
  localparam logic signed [W-1:0] DT_Q    = W'(DT_RAW);
  localparam logic signed [W-1:0] VREST_Q = W'(VREST_RAW);

  logic signed [W-1:0] leak_d;  // v - v_rest
  logic signed [W-1:0] drive_d; // I - (v - v_rest)

  lif_qaddsub #(.W(W), .SUB(1'b1)) u_leak (
    .a_i(v_i), .b_i(VREST_Q), .y_o(leak_d)
  );

  lif_qaddsub #(.W(W), .SUB(1'b1)) u_drive (
    .a_i(cur_i), .b_i(leak_d), .y_o(drive_d)
  );

  lif_qmul #(.W(W), .F(F)) u_scale (
    .a_i(DT_Q), .b_i(drive_d), .y_o(prod_o)
  );

  lif_qdiv #(.W(W), .F(F), .DEN(TAU_RAW)) u_tau (
    .num_i(prod_o), .quo_o(quot_o)
  );

  lif_qaddsub #(.W(W), .SUB(1'b0)) u_integ (
    .a_i(v_i), .b_i(quot_o), .y_o(v_next_o)
  );
endmodule

// File: rtl/lif_neuron.sv
module lif_neuron
  import lif_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter int FRAC       = 8,
  parameter int DT_RAW     = 1 << FRAC,
  parameter int TAU_RAW    = 10 << FRAC,
  parameter int VREST_RAW  = 0,
  parameter int VTH_RAW    = 1 << FRAC,
  parameter int VRESET_RAW = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [WIDTH-1:0] i_cur,
  output logic                    spike_out,
  output logic signed [WIDTH-1:0] v_out
);
  localparam longint QMAX = (longint'(1) <<< (WIDTH - 1)) - 1;
  localparam logic signed [WIDTH-1:0] VREST_Q  = WIDTH'(VREST_RAW);
  localparam logic signed [WIDTH-1:0] VTH_Q    = WIDTH'(VTH_RAW);
  localparam logic signed [WIDTH-1:0] VRESET_Q = WIDTH'(VRESET_RAW);

  // Elaboration-time guards on the encoded constants.
  generate
    if (FRAC < 1 || FRAC >= WIDTH) begin : g_bad_frac
      $error("lif_neuron: FRAC must lie in 1..WIDTH-1");
    end
    if (DT_RAW <= 0) begin : g_bad_dt
      $error("lif_neuron: time step encodes to zero; Euler update would vanish");
    end
    if (TAU_RAW <= 0) begin : g_bad_tau
      $error("lif_neuron: time constant encodes to zero or below one LSB");
    end
    if (longint'(TAU_RAW) > QMAX || longint'(DT_RAW) > QMAX) begin : g_bad_range
      $error("lif_neuron: time step or time constant exceeds the format range");
    end
  endgenerate

  logic signed [WIDTH-1:0] v_q, v_d, v_next, prod, quot;
  logic                    spike_q, spike_d;
  upd_e                    upd_mode;

  lif_update #(
    .W(WIDTH), .F(FRAC), .DT_RAW(DT_RAW), .TAU_RAW(TAU_RAW), .VREST_RAW(VREST_RAW)
  ) u_update (
    .v_i(v_q), .cur_i(i_cur), .prod_o(prod), .quot_o(quot), .v_next_o(v_next)
  );

  // Next-state: threshold tested on the freshly computed voltage.
  always_comb begin
    upd_mode = (v_next > VTH_Q) ? UPD_FIRE : UPD_INTEGRATE;
    case (upd_mode)
      UPD_FIRE: begin
        v_d     = VRESET_Q;
        spike_d = 1'b1;
      end
      default: begin
        v_d     = v_next;
        spike_d = 1'b0;
      end
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= VREST_Q;
      spike_q <= 1'b0;
    end else begin
      v_q     <= v_d;
      spike_q <= spike_d;
    end
  end

  assign v_out     = v_q;
  assign spike_out = spike_q;

  // A step above threshold reports a spike on that edge and reloads (R4).
  assert_fire_on_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (v_next > VTH_Q) |=> (spike_out && v_out == VRESET_Q));

  // A step at or below threshold stores the computed voltage (R5).
  assert_keep_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(v_next > VTH_Q) |=> (!spike_out && v_out == $past(v_next)));

  // Quotient sign follows the numerator sign for a positive divisor (R3).
  assert_div_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!prod[WIDTH-1]) |-> (!quot[WIDTH-1]));

  // Integrating a non-negative step never lowers the voltage (R6).
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_q[WIDTH-1] && !quot[WIDTH-1]) |-> (v_next >= v_q));

  // Integrating a non-positive step never raises the voltage (R6).
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q[WIDTH-1] && (quot[WIDTH-1] || quot == '0)) |-> (v_next <= v_q));

  // At rest with no input there is nothing to fire (R7).
  generate
    if (VREST_RAW <= VTH_RAW) begin : g_rest_check
      assert_quiet_at_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (i_cur == '0 && v_q == VREST_Q) |=> !spike_out);
    end
  endgenerate
endmodule

// File: tb/lif_neuron_test.sv
module lif_neuron_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n;
  longint cur [4];

  // Instance configs: 0 Q8.8 ref, 1 Q4.12, 2 Q16.16, 3 Q8.8 saturation.
  localparam int     CW   [4] = '{16, 16, 32, 16};
  localparam int     CF   [4] = '{8, 12, 16, 8};
  localparam longint CDT  [4] = '{256, 4096, 65536, 1024};
  localparam longint CTAU [4] = '{2560, 16384, 655360, 256};
  localparam longint CTH  [4] = '{256, 4096, 65536, 32767};

  logic signed [15:0] i0, i1, i3, v0, v1, v3;
  logic signed [31:0] i2, v2;
  logic s0, s1, s2, s3;

  assign i0 = 16'(cur[0]);
  assign i1 = 16'(cur[1]);
  assign i2 = 32'(cur[2]);
  assign i3 = 16'(cur[3]);

  lif_neuron uut (.clk(clk), .rst_n(rst_n), .i_cur(i0), .spike_out(s0), .v_out(v0));

  lif_neuron #(.WIDTH(16), .FRAC(12), .DT_RAW(4096), .TAU_RAW(16384),
               .VREST_RAW(0), .VTH_RAW(4096), .VRESET_RAW(0))
    uut_q412 (.clk(clk), .rst_n(rst_n), .i_cur(i1), .spike_out(s1), .v_out(v1));

  lif_neuron #(.WIDTH(32), .FRAC(16), .DT_RAW(65536), .TAU_RAW(655360),
               .VREST_RAW(0), .VTH_RAW(65536), .VRESET_RAW(0))
    uut_q1616 (.clk(clk), .rst_n(rst_n), .i_cur(i2), .spike_out(s2), .v_out(v2));

  lif_neuron #(.WIDTH(16), .FRAC(8), .DT_RAW(1024), .TAU_RAW(256),
               .VREST_RAW(0), .VTH_RAW(32767), .VRESET_RAW(0))
    uut_sat (.clk(clk), .rst_n(rst_n), .i_cur(i3), .spike_out(s3), .v_out(v3));

  int checks = 0;
  int failures = 0;
  longint mv [4];
  int spk [4];
  int cyc = 0;

  function automatic longint sat(longint x, int w);
    longint hi = (longint'(1) <<< (w - 1)) - 1;
    longint lo = -(longint'(1) <<< (w - 1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  function automatic longint obs_v(int k);
    case (k)
      0: return longint'(v0);
      1: return longint'(v1);
      2: return longint'(v2);
      default: return longint'(v3);
    endcase
  endfunction

  function automatic bit obs_s(int k);
    case (k)
      0: return s0;
      1: return s1;
      2: return s2;
      default: return s3;
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s cycle=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  // Model: one Euler step per cycle, rest voltage 0, reset voltage 0.
  task automatic model_step(int k);
    int     w = CW[k];
    int     f = CF[k];
    longint leak, drive, p, q, vn;
    leak  = sat(mv[k] - 0, w);
    drive = sat(cur[k] - leak, w);
    p     = sat((CDT[k] * drive) >>> f, w);
    q     = sat((p <<< f) / CTAU[k], w);
    vn    = sat(mv[k] + q, w);
    if (vn > CTH[k]) begin
      mv[k] = 0;
      spk[k]++;
      check(obs_s(k) == 1'b1, (k == 1 || k == 2) ? "R9/R4" : "R4",
            $sformatf("spike inst%0d", k), longint'(obs_s(k)), 1);
    end else begin
      mv[k] = vn;
      check(obs_s(k) == 1'b0, (k == 1 || k == 2) ? "R9/R5" : "R5",
            $sformatf("spike inst%0d", k), longint'(obs_s(k)), 0);
    end
    check(obs_v(k) == mv[k], (k == 1 || k == 2) ? "R9/R2" : "R2",
          $sformatf("v_out inst%0d", k), obs_v(k), mv[k]);
  endtask

  task automatic run_cycles(int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      for (int k = 0; k < 4; k++) model_step(k);
    end
  endtask

  task automatic check_reset_state(string what);
    for (int k = 0; k < 4; k++) begin
      check(obs_v(k) == 0, "R1", {what, " v_out"}, obs_v(k), 0);
      check(obs_s(k) == 1'b0, "R1", {what, " spike"}, longint'(obs_s(k)), 0);
      mv[k] = 0;
      spk[k] = 0;
    end
  endtask

  initial begin
    rst_n = 1'b0;
    cur[0] = 12800;   // 50.0 in Q8.8
    cur[1] = 8192;    // 2.0 in Q4.12
    cur[2] = 0;       // zero current in Q16.16
    cur[3] = 32767;   // drives saturation upward
    repeat (3) @(negedge clk);
    check_reset_state("initial reset");
    rst_n = 1'b1;

    // Phase A
    run_cycles(1);
    check(v1 == 16'sd2048, "R2", "Q4.12 first step", longint'(v1), 2048);
    check(v3 == 16'sd32767, "R6", "upward clamp", longint'(v3), 32767);
    run_cycles(199);
    check(spk[0] == 200, "R8", "Q8.8 spikes at I=50", spk[0], 200);
    check(spk[2] == 0, "R7", "Q16.16 zero-current spikes", spk[2], 0);
    check(spk[1] > 0, "R9", "Q4.12 spikes at I=2.0", spk[1], 1);

    // Phase B: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset_state("async reset");
    cur[0] = 0;
    cur[1] = -4096;   // -1.0 in Q4.12
    cur[2] = 196608;  // 3.0 in Q16.16
    cur[3] = -32768;  // drives saturation downward
    @(negedge clk);
    rst_n = 1'b1;
    run_cycles(1);
    check(v2 == 32'sd19660, "R3", "Q16.16 scaled divide", longint'(v2), 19660);
    check(v3 == -16'sd32768, "R6", "downward clamp", longint'(v3), -32768);
    run_cycles(99);
    check(spk[0] == 0, "R7", "Q8.8 zero-current spikes", spk[0], 0);
    check(spk[1] == 0, "R9", "Q4.12 negative-current spikes", spk[1], 0);
    cur[0] = 1280;    // 5.0 in Q8.8: periodic firing
    run_cycles(100);
    check(spk[0] > 0 && spk[0] < 100, "R5", "Q8.8 periodic spikes", spk[0], 1);
    check(spk[2] > 0, "R9", "Q16.16 spikes at I=3.0", spk[2], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired cycle=%0d actual=running expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule